// File: doc/BRIEF.md
# Regulator Startup Sequencer and Fault Supervisor

This block steps a multiphase regulator from enable to power good and then watches it for shutdown faults. When enable is high and the supply is above its lockout level, the block runs a fixed initialization step. Configuration is read and the phases are detected during this step. A reference ramp follows, and its length is picked by a small code. Power good is released once that ramp has elapsed and the reference reports that it has reached its target.

From the start of initialization onward, the block watches the comparator flags from the analog side. Overvoltage and undervoltage must persist for a set number of cycles before they act. Thermal shutdown, the external temperature latch and input lockout act at once. Any fault moves the block to a latched fault state. In that state the drivers are off and power good is pulled low. The latch clears only when enable drops or the supply lockout asserts, and either one returns the block to standby.

All time windows are counted in clock cycles and set by parameters. The defaults assume a 50 MHz clock: a 5 us persistence filter, an initialization step under 1 ms, and ramp steps of 250 us.

Top module: `ss_startup_supervisor`

## Requirements
- R1: After reset the block is in standby. The state encodings are standby=0, init=1, ramp=2, done=3 and fault=4. In standby drv_en, ramp_en and phase_det are low and pgood_pull_low is high.
- R2: With en high and vcc_uvlo low, standby moves to init on the next clock. Init lasts max(INIT_CYC, DETECT_CYC) cycles and is always followed by ramp unless a fault occurs.
- R3: phase_det is high for the first DETECT_CYC cycles of init and at no other time.
- R4: Ramp lasts (code+1)*RAMP_UNIT cycles. The code is ramp_code as sampled on the clock that leaves init, and later changes to ramp_code have no effect on the current ramp. ramp_en is high exactly in ramp.
- R5: Done is entered only when the ramp time has elapsed and ref_reached is high; ramp waits for ref_reached. pgood_pull_low is low only in done, and drv_en is high exactly in ramp and done.
- R6: ov_flag is honoured in ramp and done. It forces fault on the FILT_CYC-th consecutive clock on which it is sampled high.
- R7: If the overvoltage or undervoltage flag drops before its count expires, that count restarts from zero. Two bursts of FILT_CYC-1 cycles separated by a low cycle cause no fault.
- R8: uv_flag is honoured only in done, with the same persistence filter. In ramp it has no effect.
- R9: tsd_flag and tmon_latch force fault on the next clock in init, ramp or done.
- R10: vin_uvlo is ignored in standby. In init, ramp or done it forces fault on the next clock.
- R11: Fault is latched. While en stays high and vcc_uvlo low, the block stays in fault with drv_en low and pgood_pull_low high, even after every flag clears.
- R12: en low or vcc_uvlo high returns the block to standby on the next clock from any state. While vcc_uvlo is high, no start occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable |
| vcc_uvlo | input | 1 | Control supply below lockout |
| vin_uvlo | input | 1 | Input supply below lockout |
| ov_flag | input | 1 | Output above reference plus overvoltage margin |
| uv_flag | input | 1 | Output below reference minus undervoltage margin |
| tsd_flag | input | 1 | Die thermal shutdown comparator, hysteresis applied upstream |
| tmon_latch | input | 1 | External temperature monitor above latch threshold |
| ramp_code | input | CODE_W | Ramp length selector |
| ref_reached | input | 1 | Reference has reached its target |
| state | output | 3 | Current sequencer state |
| drv_en | output | 1 | Gate driver enable |
| ramp_en | output | 1 | Reference ramp enable |
| phase_det | output | 1 | Phase detection window strobe |
| pgood_pull_low | output | 1 | Open-drain power-good pull-down, high means pulled low |

## Verification
The hardest situations to reach are the edges of the persistence filters. A flag must be held for exactly one cycle fewer or exactly as many cycles as the filter length, while the block sits in a state where that flag is honoured. The bench first drives the block into done, or holds it in ramp by keeping ref_reached low. It then applies bursts of lengths that are set directly or drawn at random around the filter length, including a burst split by a single low cycle. Changing the ramp code in the middle of a ramp is covered on randomly chosen startups.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [2:0] {
    ST_STANDBY = 3'd0,
    ST_INIT    = 3'd1,
    ST_RAMP    = 3'd2,
    ST_DONE    = 3'd3,
    ST_FAULT   = 3'd4
  } ss_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Ramp duration in cycles for a given selector code.
  function automatic int unsigned ramp_cycles(input int unsigned code, input int unsigned unit);
    return (code + 1) * unit;
  endfunction

endpackage

// File: rtl/ss_persist_filter.sv
module ss_persist_filter #(
  parameter int unsigned LEN = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon,
  input  logic flag,
  output logic trip
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] run_q;
  logic          live;

  assign live = mon && flag;
  assign trip = live && (run_q == CW'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (!live)  run_q <= '0;
    else if (!trip)  run_q <= run_q + CW'(1);
  end
endmodule

// File: rtl/ss_fault_mon.sv
module ss_fault_mon #(
  parameter int unsigned FILT_CYC = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ss_pkg::ss_state_e st,
  input  logic              ov_flag,
  input  logic              uv_flag,
  input  logic              tsd_flag,
  input  logic              tmon_latch,
  input  logic              vin_uvlo,
  output logic              ov_trip,
  output logic              uv_trip,
  output logic              fault_now
);
  import ss_pkg::*;

  logic       active;
  logic [1:0] flt_flag, flt_mon, flt_trip;

  assign active = (st == ST_INIT) || (st == ST_RAMP) || (st == ST_DONE);

  // index 0: overvoltage (ramp and done), index 1: undervoltage (done only)
  assign flt_flag = {uv_flag, ov_flag};
  assign flt_mon  = {(st == ST_DONE), (st == ST_RAMP) || (st == ST_DONE)};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    ss_persist_filter #(.LEN(FILT_CYC)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .mon  (flt_mon[i]),
      .flag (flt_flag[i]),
      .trip (flt_trip[i])
    );
  end

  assign ov_trip   = flt_trip[0];
  assign uv_trip   = flt_trip[1];
  assign fault_now = ov_trip || uv_trip ||
                     (active && (tsd_flag || tmon_latch || vin_uvlo));
endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm #(
  parameter int unsigned INIT_LEN   = 48000,
  parameter int unsigned DETECT_CYC = 40000,
  parameter int unsigned RAMP_UNIT  = 12500,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned TW         = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              vcc_uvlo,
  input  logic              fault_now,
  input  logic              ref_reached,
  input  logic [CODE_W-1:0] ramp_code,
  output ss_pkg::ss_state_e st_q,
  output logic              init_done,
  output logic              ramp_done,
  output logic              drv_en,
  output logic              ramp_en,
  output logic              phase_det,
  output logic              pgood_pull_low
);
  import ss_pkg::*;

  ss_state_e         nxt;
  logic [TW-1:0]     tmr_q;
  logic [CODE_W-1:0] code_q;
  logic [TW-1:0]     ramp_len;

  assign ramp_len  = TW'(ramp_cycles(32'(code_q), RAMP_UNIT));
  assign init_done = (tmr_q == TW'(INIT_LEN - 1));
  assign ramp_done = (tmr_q >= (ramp_len - TW'(1)));

  always_comb begin
    nxt = st_q;
    if (vcc_uvlo || !en) nxt = ST_STANDBY;
    else begin
      unique case (st_q)
        ST_STANDBY: nxt = ST_INIT;
        ST_INIT:    if (fault_now) nxt = ST_FAULT;
                    else if (init_done) nxt = ST_RAMP;
        ST_RAMP:    if (fault_now) nxt = ST_FAULT;
                    else if (ramp_done && ref_reached) nxt = ST_DONE;
        ST_DONE:    if (fault_now) nxt = ST_FAULT;
        ST_FAULT:   nxt = ST_FAULT;
        default:    nxt = ST_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_STANDBY;
      tmr_q  <= '0;
      code_q <= '0;
    end else begin
      st_q <= nxt;
      if (nxt != st_q)        tmr_q <= '0;
      else if (tmr_q != '1)   tmr_q <= tmr_q + TW'(1);
      if (st_q == ST_INIT && nxt == ST_RAMP) code_q <= ramp_code;
    end
  end

  assign drv_en         = (st_q == ST_RAMP) || (st_q == ST_DONE);
  assign ramp_en        = (st_q == ST_RAMP);
  assign phase_det      = (st_q == ST_INIT) && (tmr_q < TW'(DETECT_CYC));
  assign pgood_pull_low = (st_q != ST_DONE);
endmodule

// File: rtl/ss_startup_supervisor.sv
module ss_startup_supervisor #(
  parameter int unsigned FILT_CYC   = 250,
  parameter int unsigned INIT_CYC   = 45000,
  parameter int unsigned DETECT_CYC = 40000,
  parameter int unsigned RAMP_UNIT  = 12500,
  parameter int unsigned CODE_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              vcc_uvlo,
  input  logic              vin_uvlo,
  input  logic              ov_flag,
  input  logic              uv_flag,
  input  logic              tsd_flag,
  input  logic              tmon_latch,
  input  logic [CODE_W-1:0] ramp_code,
  input  logic              ref_reached,
  output logic [2:0]        state,
  output logic              drv_en,
  output logic              ramp_en,
  output logic              phase_det,
  output logic              pgood_pull_low
);
  import ss_pkg::*;

  localparam int unsigned INIT_LEN = max_u(INIT_CYC, DETECT_CYC);
  localparam int unsigned RAMP_MAX = (1 << CODE_W) * RAMP_UNIT;
  localparam int unsigned TW       = $clog2(max_u(INIT_LEN, RAMP_MAX) + 1);

  ss_state_e st_q;
  logic      ov_trip, uv_trip, fault_now, init_done, ramp_done;

  ss_fault_mon #(.FILT_CYC(FILT_CYC)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st_q),
    .ov_flag   (ov_flag),
    .uv_flag   (uv_flag),
    .tsd_flag  (tsd_flag),
    .tmon_latch(tmon_latch),
    .vin_uvlo  (vin_uvlo),
    .ov_trip   (ov_trip),
    .uv_trip   (uv_trip),
    .fault_now (fault_now)
  );

  ss_seq_fsm #(
    .INIT_LEN  (INIT_LEN),
    .DETECT_CYC(DETECT_CYC),
    .RAMP_UNIT (RAMP_UNIT),
    .CODE_W    (CODE_W),
    .TW        (TW)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .vcc_uvlo      (vcc_uvlo),
    .fault_now     (fault_now),
    .ref_reached   (ref_reached),
    .ramp_code     (ramp_code),
    .st_q          (st_q),
    .init_done     (init_done),
    .ramp_done     (ramp_done),
    .drv_en        (drv_en),
    .ramp_en       (ramp_en),
    .phase_det     (phase_det),
    .pgood_pull_low(pgood_pull_low)
  );

  assign state = st_q;
endmodule

// File: rtl/ss_startup_checker.sv
module ss_startup_checker #(
  parameter int unsigned FILT = 250
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       vcc_uvlo,
  input logic       ov_flag,
  input logic       ov_trip,
  input logic       uv_trip,
  input logic [2:0] state,
  input logic       drv_en,
  input logic       phase_det,
  input logic       pgood_pull_low
);
  logic [31:0] ov_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_run <= '0;
    else if (ov_flag && (state == 3'd2 || state == 3'd3)) ov_run <= ov_run + 32'd1;
    else ov_run <= '0;
  end

  AST_START_VIA_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 3'd0 && state != 3'd0) |-> state == 3'd1); // R2
  AST_DETECT_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    phase_det |-> state == 3'd1); // R3
  AST_PGOOD_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgood_pull_low) |-> $past(state) == 3'd2); // R5
  AST_OV_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    ov_trip |-> ov_run == 32'(FILT - 1)); // R6
  AST_UV_DONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    uv_trip |-> state == 3'd3); // R8
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && en && !vcc_uvlo) |=> state == 3'd4); // R11
  AST_DRV_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 || state == 3'd4) |-> !drv_en); // R11
  AST_DISABLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || vcc_uvlo) |=> state == 3'd0); // R12
endmodule

bind ss_startup_supervisor ss_startup_checker #(.FILT(FILT_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en            (en),
  .vcc_uvlo      (vcc_uvlo),
  .ov_flag       (ov_flag),
  .ov_trip       (ov_trip),
  .uv_trip       (uv_trip),
  .state         (state),
  .drv_en        (drv_en),
  .phase_det     (phase_det),
  .pgood_pull_low(pgood_pull_low)
);

// File: tb/ss_startup_supervisor_tb.sv
module ss_startup_supervisor_tb;
  localparam int F = 8, INIT = 20, DET = 12, UNIT = 10, CW = 3;
  localparam int INIT_LEN = (INIT > DET) ? INIT : DET;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic en = 0, vcc_uvlo = 0, vin_uvlo = 0, ov = 0, uv = 0, tsd = 0, tmon = 0, ref_ok = 1;
  logic [CW-1:0] code = '0;
  logic [2:0] state;
  logic drv_en, ramp_en, phase_det, pg_low;
  int checks = 0, fails = 0;

  ss_startup_supervisor #(.FILT_CYC(F), .INIT_CYC(INIT), .DETECT_CYC(DET),
                          .RAMP_UNIT(UNIT), .CODE_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .vcc_uvlo(vcc_uvlo), .vin_uvlo(vin_uvlo),
    .ov_flag(ov), .uv_flag(uv), .tsd_flag(tsd), .tmon_latch(tmon),
    .ramp_code(code), .ref_reached(ref_ok), .state(state), .drv_en(drv_en),
    .ramp_en(ramp_en), .phase_det(phase_det), .pgood_pull_low(pg_low));

  function automatic int exp_ramp(input int c);
    return UNIT * (c + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Enable and walk to done, measuring the time spent in each state.
  task automatic start_to_done(input int c, input bit flip);
    int ni = 0, np = 0, nd = 0, nr = 0, nre = 0, guard = 0;
    code = CW'(c);
    en = 1;
    step(1);
    while (state == 3'd1 && guard < 500) begin
      ni++; if (phase_det) np++; if (drv_en) nd++;
      step(1); guard++;
    end
    while (state == 3'd2 && guard < 500) begin
      nr++; if (ramp_en) nre++;
      if (flip && nr == 2) code = ~CW'(c);
      step(1); guard++;
    end
    chk("R2 init length", ni, INIT_LEN);
    chk("R3 detect window", np, DET);
    chk("R5 drv_en low in init", nd, 0);
    chk("R4 ramp length", nr, exp_ramp(c));
    chk("R4 ramp_en in ramp", nre, nr);
    chk("R5 reached done", state, 3);
    chk("R5 power good released", pg_low, 0);
    chk("R5 drv_en in done", drv_en, 1);
    code = CW'(c);
  endtask

  task automatic to_standby();
    en = 0; step(1);
    chk("R12 en low to standby", state, 0);
  endtask

  // Enable with ref held low; returns while sitting in ramp.
  task automatic hold_in_ramp();
    ref_ok = 0; en = 1;
    step(INIT_LEN + 3);
    chk("R5 waits for reference", state, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    step(2); rst_n = 1; step(1);
    chk("R1 state", state, 0);
    chk("R1 drv_en", drv_en, 0);
    chk("R1 ramp_en", ramp_en, 0);
    chk("R1 phase_det", phase_det, 0);
    chk("R1 pull low", pg_low, 1);

    vcc_uvlo = 1; en = 1; step(5);
    chk("R12 vcc lockout blocks start", state, 0);
    en = 0; vcc_uvlo = 0; vin_uvlo = 1; step(5);
    chk("R10 vin lockout ignored in standby", state, 0);
    vin_uvlo = 0;

    for (int i = 0; i < 6; i++) begin
      start_to_done(int'($urandom % 8), 1'($urandom % 2));
      to_standby();
    end
    start_to_done(7, 1'b1); to_standby();
    start_to_done(0, 1'b0); to_standby();

    // Reference wait with undervoltage during ramp
    code = 3'd1;
    hold_in_ramp();
    uv = 1; step(3 * F + exp_ramp(1));
    chk("R8 uv ignored in ramp", state, 2);
    chk("R5 no power good before reference", pg_low, 1);
    uv = 0; ref_ok = 1; step(1);
    chk("R5 done after reference", state, 3);

    // Filter restart, then a full burst
    ov = 1; step(F - 1); ov = 0; step(1); ov = 1; step(F - 1); ov = 0; step(3);
    chk("R7 split bursts no fault", state, 3);
    ov = 1; step(F - 1);
    chk("R6 short of filter", state, 3);
    step(1);
    chk("R6 overvoltage trip", state, 4);
    ov = 0; step(5);
    chk("R11 fault held", state, 4);
    chk("R11 drv_en off", drv_en, 0);
    chk("R11 pulled low", pg_low, 1);
    to_standby();

    // Overvoltage in ramp
    hold_in_ramp();
    ov = 1; step(F); ov = 0;
    chk("R6 trip in ramp", state, 4);
    to_standby(); ref_ok = 1;

    // Undervoltage in done, clear by vcc lockout, thermal in init
    start_to_done(2, 1'b0);
    uv = 1; step(F); uv = 0;
    chk("R8 uv trip in done", state, 4);
    vcc_uvlo = 1; step(1);
    chk("R12 vcc lockout clears fault", state, 0);
    vcc_uvlo = 0; step(1);
    chk("R2 restart into init", state, 1);
    tsd = 1; step(1); tsd = 0;
    chk("R9 thermal shutdown in init", state, 4);
    to_standby();

    start_to_done(4, 1'b0);
    tmon = 1; step(1); tmon = 0;
    chk("R9 temperature latch in done", state, 4);
    to_standby();

    hold_in_ramp();
    vin_uvlo = 1; step(1); vin_uvlo = 0;
    chk("R10 vin lockout in ramp", state, 4);
    to_standby(); ref_ok = 1;

    // Random burst lengths around the filter length
    for (int i = 0; i < 16; i++) begin
      int k;
      bit use_uv;
      k = 1 + int'($urandom % (2 * F));
      use_uv = 1'($urandom % 2);
      start_to_done(int'($urandom % 4), 1'b0);
      if (use_uv) uv = 1; else ov = 1;
      step(k); uv = 0; ov = 0; step(1);
      chk(use_uv ? "R8 random uv burst" : "R6 random ov burst",
          state, (k >= F) ? 4 : 3);
      to_standby();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule